// File: doc/BRIEF.md
# Channel-Status Block Sequencer

This block moves the 192-bit channel-status block of an S/PDIF-style audio link, one bit per frame, in both directions. The transmit side keeps six 32-bit page words loaded through a small write port. On each frame strobe it presents one bit on `tx_bit`. Bits go out least significant first within a word, and the words go in order from page 0 to page 5 before wrapping back to page 0. A busy flag shows which part of the block is being shifted.

The receive side takes one channel-status bit per received frame and writes it into its own six page words in the same order. A block-start indication (the B preamble) moves the capture pointer back to bit 0 of page 0, so the capture stays aligned to the block. Two sticky flags record a completed block and a seen block start. Software clears them by writing ones. An interrupt line combines each flag with its own enable.

Biphase coding, preamble detection and audio samples are outside this block. It only receives strobes and bits from the framing logic around it.

Top module: `cs_block_seq`

## Requirements
- R1: After reset, `tx_bit`, `tx_busy`, `irq`, both sticky flags and all receive page words are 0.
- R2: When `tx_en` and `cs_en` are both high, the first `frame_end` strobe loads page 0 into the shifter. `tx_busy` rises and `tx_bit` shows page 0 bit 0 in the cycle after that strobe.
- R3: Each later `frame_end` advances one bit: least significant bit first within a page, pages 0 to 5. Strobe k after the start shows bit (k-1) mod 32 of page ((k-1)/32) mod 6. `tx_bit` changes only on a strobe.
- R4: `tx_busy` falls on the strobe that loads page 5 (strobe 161) and stays low through strobe 192. It rises again on strobe 193, when page 0 is reloaded.
- R5: When `tx_en` or `cs_en` is low, `tx_busy` holds until the next `frame_end`. That strobe clears `tx_busy`, drives `tx_bit` to 0, and makes the next enabled strobe start again at page 0 bit 0.
- R6: Page words written at addresses 0 to 5 are taken up when that page is next loaded into the shifter. A running shift is not disturbed by such a write.
- R7: A receive strobe (`rx_frame` with `rx_en` high) writes `rx_bit` into the receive page bit at the capture pointer. The pointer advances LSB first, pages 0 to 5, and then wraps to page 0. Page i appears at `rx_pages[32*i +: 32]`. When `rx_en` is low, `rx_frame` is ignored.
- R8: The receive strobe that fills page 5 bit 31 sets the sticky block-done flag (status bit 0) at the same edge.
- R9: A receive strobe with `rx_bstart` high stores its bit at page 0 bit 0, moves the pointer to page 0 bit 1, and sets the sticky block-start flag (status bit 1).
- R10: Writing address 7 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R11: `irq` is high exactly when some flag is set and its enable is set. The enables are written at address 6: bit 0 enables block-done and bit 1 enables block-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| cs_en | input | 1 | Channel-status transmit enable |
| frame_end | input | 1 | One-cycle strobe at each transmit frame boundary |
| rx_en | input | 1 | Receive enable |
| rx_frame | input | 1 | One-cycle strobe for each received frame |
| rx_bit | input | 1 | Channel-status bit of the received frame |
| rx_bstart | input | 1 | Received frame carries a block-start preamble |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-5 transmit pages, 6 interrupt enables, 7 flag clear |
| wr_data | input | 32 | Write data |
| tx_bit | output | 1 | Current transmit channel-status bit |
| tx_busy | output | 1 | Transmit shifter busy |
| rx_pages | output | 192 | Six receive page words, page 0 in the low bits |
| blk_done | output | 1 | Sticky block-received flag |
| bstart_seen | output | 1 | Sticky block-start flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong transmit pointer shows up as a wrong `tx_bit` at the very next frame strobe. Every bit of a full block, including the wrap back to page 0, is compared against the written pages. A wrong busy edge shows at strobes 1, 160, 161, 192 and 193. A receive pointer that is misaligned or has slipped leaves a wrong bit in `rx_pages` one cycle after the strobe that wrote it. A block-done flag that comes one bit early or late shows when the flag is sampled after bits 191 and 192.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  parameter int CS_WORD_W = 32;
  parameter int CS_NUM_PAGES = 6;
  localparam int FLG_DONE = 0;
  localparam int FLG_BST = 1;
  localparam int FLG_N = 2;
endpackage

// File: rtl/cs_tx_engine.sv
module cs_tx_engine #(
  parameter int WORD_W = cs_seq_pkg::CS_WORD_W,
  parameter int NUM_PAGES = cs_seq_pkg::CS_NUM_PAGES,
  localparam int PG_W = $clog2(NUM_PAGES),
  localparam int BT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic              go,
  input  logic              wr_pg,
  input  logic [PG_W-1:0]   wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic              tx_bit,
  output logic              tx_busy
);
  localparam logic [PG_W-1:0] LAST_P = PG_W'(NUM_PAGES - 1);
  localparam logic [BT_W-1:0] LAST_B = BT_W'(WORD_W - 1);

  logic [WORD_W-1:0] page_q [NUM_PAGES];
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [PG_W-1:0]   pg_q, pg_d, pg_nx;
  logic [BT_W-1:0]   bt_q, bt_d;
  logic              run_q, run_d, busy_q, busy_d;

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_page
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) page_q[i] <= '0;
      else if (wr_pg && wr_sel == PG_W'(i)) page_q[i] <= wr_data;
    end
  end

  always_comb begin
    sh_d = sh_q; pg_d = pg_q; bt_d = bt_q; run_d = run_q; busy_d = busy_q;
    pg_nx = (pg_q == LAST_P) ? '0 : pg_q + 1'b1;
    if (frame_end) begin
      if (!go) begin
        sh_d = '0; pg_d = '0; bt_d = '0; run_d = 1'b0; busy_d = 1'b0;
      end else if (!run_q) begin
        sh_d = page_q[0]; pg_d = '0; bt_d = '0; run_d = 1'b1; busy_d = 1'b1;
      end else if (bt_q == LAST_B) begin
        sh_d = page_q[pg_nx]; pg_d = pg_nx; bt_d = '0;
        if (pg_nx == '0) busy_d = 1'b1;
        else if (pg_nx == LAST_P) busy_d = 1'b0;
      end else begin
        sh_d = sh_q >> 1; bt_d = bt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; pg_q <= '0; bt_q <= '0; run_q <= 1'b0; busy_q <= 1'b0;
    end else if (frame_end) begin
      sh_q <= sh_d; pg_q <= pg_d; bt_q <= bt_d; run_q <= run_d; busy_q <= busy_d;
    end
  end

  assign tx_bit  = sh_q[0];
  assign tx_busy = busy_q;
endmodule

// File: rtl/cs_rx_engine.sv
module cs_rx_engine #(
  parameter int WORD_W = cs_seq_pkg::CS_WORD_W,
  parameter int NUM_PAGES = cs_seq_pkg::CS_NUM_PAGES,
  localparam int PG_W = $clog2(NUM_PAGES),
  localparam int BT_W = $clog2(WORD_W)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_v,
  input  logic                        rx_bit,
  input  logic                        rx_bstart,
  output logic [NUM_PAGES*WORD_W-1:0] pages,
  output logic                        blk_end
);
  localparam logic [PG_W-1:0] LAST_P = PG_W'(NUM_PAGES - 1);
  localparam logic [BT_W-1:0] LAST_B = BT_W'(WORD_W - 1);

  logic [PG_W-1:0] pg_q, pg_d, tgt_pg;
  logic [BT_W-1:0] bt_q, bt_d, tgt_bt;

  always_comb begin
    tgt_pg = rx_bstart ? '0 : pg_q;
    tgt_bt = rx_bstart ? '0 : bt_q;
    if (tgt_bt == LAST_B) begin
      bt_d = '0;
      pg_d = (tgt_pg == LAST_P) ? '0 : tgt_pg + 1'b1;
    end else begin
      bt_d = tgt_bt + 1'b1;
      pg_d = tgt_pg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= '0; bt_q <= '0;
    end else if (rx_v) begin
      pg_q <= pg_d; bt_q <= bt_d;
    end
  end

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_rpage
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (rx_v && tgt_pg == PG_W'(i)) word_q[tgt_bt] <= rx_bit;
    end
    assign pages[i*WORD_W +: WORD_W] = word_q;
  end

  assign blk_end = rx_v && tgt_pg == LAST_P && tgt_bt == LAST_B;
endmodule

// File: rtl/cs_flags.sv
module cs_flags #(
  parameter int FLG_N = cs_seq_pkg::FLG_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_N-1:0] set_v,
  input  logic             clr_wr,
  input  logic             en_wr,
  input  logic [FLG_N-1:0] wdata,
  output logic [FLG_N-1:0] flags,
  output logic             irq
);
  logic [FLG_N-1:0] flg_q, flg_d, en_q;

  always_comb begin
    flg_d = flg_q;
    if (clr_wr) flg_d = flg_d & ~wdata;
    flg_d = flg_d | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0; en_q <= '0;
    end else begin
      flg_q <= flg_d;
      if (en_wr) en_q <= wdata;
    end
  end

  assign flags = flg_q;
  assign irq   = |(flg_q & en_q);
endmodule

// File: rtl/cs_block_seq.sv
module cs_block_seq #(
  parameter int WORD_W = cs_seq_pkg::CS_WORD_W,
  parameter int NUM_PAGES = cs_seq_pkg::CS_NUM_PAGES,
  localparam int ADDR_W = $clog2(NUM_PAGES + 2),
  localparam int PG_W = $clog2(NUM_PAGES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tx_en,
  input  logic                        cs_en,
  input  logic                        frame_end,
  input  logic                        rx_en,
  input  logic                        rx_frame,
  input  logic                        rx_bit,
  input  logic                        rx_bstart,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  output logic                        tx_bit,
  output logic                        tx_busy,
  output logic [NUM_PAGES*WORD_W-1:0] rx_pages,
  output logic                        blk_done,
  output logic                        bstart_seen,
  output logic                        irq
);
  import cs_seq_pkg::*;
  localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(NUM_PAGES);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_PAGES + 1);

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic             rx_v, blk_end;
  logic [FLG_N-1:0] set_v, flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign rx_v = rx_en && rx_frame;

  cs_tx_engine #(.WORD_W(WORD_W), .NUM_PAGES(NUM_PAGES)) u_tx (
    .clk(clk), .rst_n(rst_i_n), .frame_end(frame_end), .go(tx_en && cs_en),
    .wr_pg(wr_en && wr_addr < EN_ADDR), .wr_sel(wr_addr[PG_W-1:0]),
    .wr_data(wr_data), .tx_bit(tx_bit), .tx_busy(tx_busy));

  cs_rx_engine #(.WORD_W(WORD_W), .NUM_PAGES(NUM_PAGES)) u_rx (
    .clk(clk), .rst_n(rst_i_n), .rx_v(rx_v), .rx_bit(rx_bit),
    .rx_bstart(rx_bstart), .pages(rx_pages), .blk_end(blk_end));

  always_comb begin
    set_v = '0;
    set_v[FLG_DONE] = blk_end;
    set_v[FLG_BST]  = rx_v && rx_bstart;
  end

  cs_flags #(.FLG_N(FLG_N)) u_flg (
    .clk(clk), .rst_n(rst_i_n), .set_v(set_v),
    .clr_wr(wr_en && wr_addr == CLR_ADDR), .en_wr(wr_en && wr_addr == EN_ADDR),
    .wdata(wr_data[FLG_N-1:0]), .flags(flags), .irq(irq));

  assign blk_done    = flags[FLG_DONE];
  assign bstart_seen = flags[FLG_BST];
endmodule

// File: rtl/cs_block_seq_chk.sv
module cs_block_seq_chk #(
  parameter int PW = 192
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          cs_en,
  input logic          frame_end,
  input logic          rx_en,
  input logic          rx_frame,
  input logic          rx_bstart,
  input logic          tx_bit,
  input logic          tx_busy,
  input logic [PW-1:0] rx_pages,
  input logic          blk_done,
  input logic          bstart_seen
);
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(frame_end && tx_en && cs_en));
  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(tx_bit) && $stable(tx_busy));
  // R5
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !(tx_en && cs_en) |=> !tx_busy && !tx_bit);
  // R7
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en && rx_frame) |=> $stable(rx_pages));
  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_done) |-> $past(rx_en && rx_frame));
  // R9
  bst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && rx_frame && rx_bstart |=> bstart_seen);
endmodule

bind cs_block_seq cs_block_seq_chk #(.PW(NUM_PAGES*WORD_W)) i_chk (
  .clk(clk), .rst_n(rst_i_n), .tx_en(tx_en), .cs_en(cs_en), .frame_end(frame_end),
  .rx_en(rx_en), .rx_frame(rx_frame), .rx_bstart(rx_bstart), .tx_bit(tx_bit),
  .tx_busy(tx_busy), .rx_pages(rx_pages), .blk_done(blk_done),
  .bstart_seen(bstart_seen));

// File: tb/test_cs_block_seq.sv
module test_cs_block_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, cs_en = 0, frame_end = 0, rx_en = 0, rx_frame = 0, rx_bit = 0, rx_bstart = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic tx_bit, tx_busy, blk_done, bstart_seen, irq;
  logic [191:0] rx_pages;
  int n_chk = 0, n_fail = 0;
  logic [31:0] txw [6];
  logic [31:0] rxw [6];

  always #2.5 clk = ~clk;

  cs_block_seq i_cs_block_seq (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic strobe();
    @(negedge clk); frame_end = 1;
    @(negedge clk); frame_end = 0;
  endtask

  task automatic rx_send(logic b, logic bs);
    @(negedge clk); rx_frame = 1; rx_bit = b; rx_bstart = bs;
    @(negedge clk); rx_frame = 0; rx_bstart = 0;
  endtask

  task automatic t_reset();
    chk("R1 tx_bit", 32'(tx_bit), 0); chk("R1 tx_busy", 32'(tx_busy), 0);
    chk("R1 irq", 32'(irq), 0); chk("R1 flags", {30'd0, bstart_seen, blk_done}, 0);
    chk("R1 rx_pages", 32'(|rx_pages), 0);
  endtask

  task automatic t_tx_block();
    for (int i = 0; i < 6; i++) begin
      txw[i] = 32'h9E37_79B9 * (i + 3) ^ (32'h0F0F_3C3C << i);
      wr(3'(i), txw[i]);
    end
    tx_en = 1; cs_en = 1;
    for (int k = 1; k <= 193; k++) begin
      strobe();
      chk("R3 tx_bit", 32'(tx_bit), 32'(txw[((k-1)/32)%6][(k-1)%32]));
      if (k == 1)   chk("R2 busy rise", 32'(tx_busy), 1);
      if (k == 160) chk("R4 busy before F", 32'(tx_busy), 1);
      if (k == 161) chk("R4 busy drop at F", 32'(tx_busy), 0);
      if (k == 192) chk("R4 busy low in F", 32'(tx_busy), 0);
      if (k == 193) chk("R4 busy on wrap", 32'(tx_busy), 1);
    end
  endtask

  task automatic t_tx_stop();
    // R6: rewrite page 1 mid-run (shifter is in page 0 after strobe 193)
    wr(3'd1, 32'hFFFF_0000);
    tx_en = 0;
    repeat (3) @(negedge clk);
    chk("R5 busy held w/o strobe", 32'(tx_busy), 1);
    strobe();
    chk("R5 busy cleared", 32'(tx_busy), 0);
    chk("R5 bit cleared", 32'(tx_bit), 0);
    tx_en = 1; cs_en = 0;
    repeat (2) strobe();
    chk("R5 cs_en low stays idle", {31'd0, tx_busy}, 0);
    cs_en = 1;
    for (int k = 1; k <= 64; k++) begin
      strobe();
      chk("R6 restart/new page", 32'(tx_bit), 32'(k <= 32 ? txw[0][k-1] : ((k-33) >= 16)));
    end
    tx_en = 0; strobe();
  endtask

  task automatic t_rx_ignore();
    rx_en = 0;
    repeat (4) rx_send(1'b1, 1'b1);
    chk("R7 ignored when disabled", 32'(|rx_pages), 0);
    chk("R9 no flag when disabled", 32'(bstart_seen), 0);
  endtask

  task automatic t_rx_block();
    rx_en = 1;
    for (int i = 0; i < 6; i++) rxw[i] = 32'hC3A5_0F01 + 32'h1357_9BDF * i;
    for (int k = 0; k < 192; k++) begin
      rx_send(rxw[k/32][k%32], k == 0);
      if (k == 0)   chk("R9 bstart flag", 32'(bstart_seen), 1);
      if (k == 190) chk("R8 not done early", 32'(blk_done), 0);
      if (k == 191) chk("R8 done at last bit", 32'(blk_done), 1);
    end
    for (int i = 0; i < 6; i++) chk("R7 rx page", rx_pages[i*32 +: 32], rxw[i]);
  endtask

  task automatic t_rx_realign();
    wr(3'd7, 32'h3);
    chk("R10 clear both", {30'd0, bstart_seen, blk_done}, 0);
    repeat (5) rx_send(1'b1, 1'b0);
    rx_send(1'b0, 1'b1);
    rx_send(1'b0, 1'b0);
    chk("R9 realign page0", rx_pages[31:0], (rxw[0] & ~32'h1F) | 32'h1C);
    chk("R9 page1 untouched", rx_pages[63:32], rxw[1]);
    chk("R9 flag on realign", 32'(bstart_seen), 1);
    chk("R8 no spurious done", 32'(blk_done), 0);
    for (int k = 2; k < 192; k++) rx_send(1'b0, 1'b0);
    chk("R8 done after realigned block", 32'(blk_done), 1);
  endtask

  task automatic t_flags();
    chk("R11 irq masked", 32'(irq), 0);
    wr(3'd6, 32'h1);
    chk("R11 irq done enabled", 32'(irq), 1);
    wr(3'd7, 32'h0);
    chk("R10 write 0 keeps", {30'd0, bstart_seen, blk_done}, 3);
    wr(3'd7, 32'h1);
    chk("R10 clear done only", {30'd0, bstart_seen, blk_done}, 2);
    chk("R11 irq drops", 32'(irq), 0);
    wr(3'd6, 32'h2);
    chk("R11 irq bstart enabled", 32'(irq), 1);
    wr(3'd7, 32'h2);
    chk("R11 irq after clear", 32'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_block();
    t_tx_stop();
    t_rx_ignore();
    t_rx_block();
    t_rx_realign();
    t_flags();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule